// File: doc/BRIEF.md
# Byte-Serial CRC-16 Update Unit

This block folds one 8-bit data byte into a 16-bit CRC accumulator. A caller presents the current accumulator value and a data word, pulses a start input, and some cycles later collects the updated accumulator. Only the low byte of the data word takes part. The caller writes the result back and feeds it in again with the next byte.

The update first XORs the data byte into the low half of the accumulator. It then applies eight bit-steps, one per clock. Each step rotates the 16-bit working value right by one place, so bit 0 moves into bit 15. If the bit that lands in position 15 is set, the step also XORs in the constant 0x2001 (octal 020001). While the steps run, a busy flag is high. A one-cycle done pulse marks the finished result, which then stays on the output until the next accepted start.

Top module: `crc16_byte_step`

## Requirements
- R1: When a start is accepted, the working value is loaded with the 16-bit crc_in XORed with the zero-extended low byte data_in[7:0].
- R2: Bits data_in[15:8] have no effect on the result.
- R3: Each bit-step rotates the working value right by one (bit 0 moves to bit 15). If bit 15 is then 1, the step XORs the value with 16'h2001.
- R4: Exactly 8 bit-steps run per byte. busy is high for exactly 8 consecutive cycles, starting the cycle after the clock edge that accepts start.
- R5: done is high for exactly one cycle. That cycle is the first cycle after busy falls, and in it crc_out shows the value after all 8 steps.
- R6: While the unit is idle, crc_out holds its value until a start is accepted. Changes on crc_in and data_in without start do not alter it.
- R7: A start asserted while busy is high is ignored, and the running update finishes with its original operands.
- R8: A synchronous active-high reset clears the working register, the step count and done, so crc_out reads 0 and busy reads 0.
- R9: A start asserted in the cycle where done is high is accepted, so back-to-back bytes need no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an update with the present crc_in and data_in |
| crc_in | input | 16 | Current accumulator value |
| data_in | input | 16 | Data word; only bits 7:0 are used |
| busy | output | 1 | High while bit-steps are in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| crc_out | output | 16 | Working value; the new accumulator once done has pulsed |

## Verification
Every byte value 0 to 255 is run against eight accumulator values: zero, all ones, a lone top bit, a lone bottom bit, two alternating patterns and two arbitrary words. With these, a wrong rotate direction, a wrong conditional XOR constant or a wrong step count each give a visibly different result. The upper data byte is filled with a changing non-zero pattern throughout the sweep, and in one case it is also varied against a fixed low byte, which shows whether it leaks into the result. Directed sequences cover a start during busy, a start in the done cycle, input changes while idle, and a reset in the middle of an update. These separate faults in the handshake from faults in the arithmetic.

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
  parameter int WIDTH = 16,
  parameter int DATA_W = 8,
  parameter int STEPS = 8,
  parameter logic [WIDTH-1:0] POLY = 16'h2001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] crc_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] crc_out
);
  localparam int CW = $clog2(STEPS + 1);

  logic [WIDTH-1:0] work;
  logic [WIDTH-1:0] rot;
  logic [CW-1:0]    left;
  logic             accept;

  assign rot     = {work[0], work[WIDTH-1:1]};
  assign busy    = (left != '0);
  assign accept  = start && !busy;
  assign crc_out = work;

  always_ff @(posedge clk) begin
    if (rst) begin
      work <= '0;
      left <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        work <= crc_in ^ {{(WIDTH-DATA_W){1'b0}}, data_in[DATA_W-1:0]};
        left <= CW'(STEPS);
      end else if (busy) begin
        work <= rot[WIDTH-1] ? (rot ^ POLY) : rot;
        left <= left - 1'b1;
        if (left == CW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

module crc16_byte_step_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] crc_out
);
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !done && crc_out == '0));

  a_r4_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(crc_out));

  a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind crc16_byte_step crc16_byte_step_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .crc_out(crc_out)
);

// File: tb/sim_crc16_byte_step.sv
`timescale 1ns/1ps
module sim_crc16_byte_step;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] crc_in = '0;
  logic [15:0] data_in = '0;
  logic        busy, done;
  logic [15:0] crc_out;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  crc16_byte_step u0 (
    .clk(clk), .rst(rst), .start(start), .crc_in(crc_in), .data_in(data_in),
    .busy(busy), .done(done), .crc_out(crc_out)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] w;
    w = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) begin
      w = {w[0], w[15:1]};
      if (w[15]) w = w ^ 16'h2001;
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] c, input logic [15:0] d, output logic [15:0] res, output int nb, output bit dn);
    @(negedge clk);
    crc_in = c; data_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 0;
    while (busy && nb < 20) begin
      nb++;
      @(negedge clk);
    end
    dn = done;
    res = crc_out;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] res, res2, held;
    int nb;
    bit dn;
    logic [15:0] seeds [8];
    seeds = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'hA5A5, 16'h5A5A, 16'h1234, 16'hFEDC};

    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && crc_out == 16'h0, "R8 reset state", {busy, done, crc_out}, 0);
    rst = 1'b0;

    // R1 R3 R4 R5: sweep of all bytes against several accumulators, upper byte R2 noise
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 256; b++) begin
        logic [15:0] d;
        d = {8'((b * 37 + s * 11) ^ 8'h5C), 8'(b)};
        run_op(seeds[s], d, res, nb, dn);
        chk(res == ref_crc(seeds[s], 8'(b)), "R1 R2 R3 sweep result", res, ref_crc(seeds[s], 8'(b)));
        chk(nb == 8, "R4 busy length", nb, 8);
        chk(dn == 1'b1, "R5 done after busy", dn, 1);
        @(negedge clk);
        chk(done == 1'b0, "R5 done single cycle", done, 0);
      end
    end

    // R3 known value: zero in, zero out
    run_op(16'h0000, 16'h0000, res, nb, dn);
    chk(res == 16'h0000, "R3 zero operands", res, 0);

    // R2 upper byte varied against fixed low byte
    run_op(16'h3C3C, 16'h0047, res, nb, dn);
    run_op(16'h3C3C, 16'hFF47, res2, nb, dn);
    chk(res == res2, "R2 upper byte ignored", res2, res);

    // R6 idle hold with changing inputs
    held = crc_out;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      crc_in = 16'(k * 4099); data_in = 16'(k * 257 + 3);
      chk(crc_out == held && !busy, "R6 idle hold", crc_out, held);
    end

    // R7 start during busy ignored
    @(negedge clk);
    crc_in = 16'hBEEF; data_in = 16'h0011; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    crc_in = 16'h1111; data_in = 16'h00EE; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 3;
    while (busy && nb < 20) begin nb++; @(negedge clk); end
    chk(nb == 8, "R7 busy length unchanged", nb, 8);
    chk(done && crc_out == ref_crc(16'hBEEF, 8'h11), "R7 original operands kept", crc_out, ref_crc(16'hBEEF, 8'h11));

    // R9 start in the done cycle
    crc_in = 16'h0F0F; data_in = 16'h0080; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 back-to-back accepted", busy, 1);
    nb = 1;
    while (busy && nb < 20) begin nb++; @(negedge clk); end
    chk(nb - 1 == 8 && done && crc_out == ref_crc(16'h0F0F, 8'h80), "R9 back-to-back result", crc_out, ref_crc(16'h0F0F, 8'h80));

    // R8 reset mid-update
    @(negedge clk);
    crc_in = 16'h7777; data_in = 16'h0033; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && crc_out == 16'h0, "R8 reset mid-update", {busy, done, crc_out}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && !done && crc_out == 16'h0, "R8 stays idle after reset", {busy, done, crc_out}, 0);

    run_op(16'h4321, 16'h00C5, res, nb, dn);
    chk(res == ref_crc(16'h4321, 8'hC5) && nb == 8, "R3 R4 after reset", res, ref_crc(16'h4321, 8'hC5));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule